// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block holds the interrupt enable register of a byte-wide UART register file. It merges five interrupt conditions into one prioritised identification byte. The receiver, transmitter and modem-status logic supply the conditions as inputs. Software writes the enable register and reads both the enable register and the identification byte through a simple address/strobe port. The block drives a single interrupt request line, and the modem-control output-enable bit gates that line.

The transmit-holding-empty condition is the only one kept as internal state. A rising edge of the empty level arms it, and so does enabling its interrupt while the holding register is already empty. Two events disarm it: software reads the identification byte while this source is the one reported, or software writes the holding register. All other conditions are levels owned by their producers.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register holds 0, the identification byte reads 0x01 with FIFOs off, and the interrupt request is low.
- R2: A write to offset 1 while the divisor-access input is low loads the low four bits of the write data into the enable register. Write data bits 7:4 are dropped, and offset 1 reads back {4'b0, enable}. The same write while divisor access is high leaves the register unchanged.
- R3: Bit 0 of the identification byte is 0 when at least one enabled source is active, and 1 otherwise.
- R4: Bits 3:0 carry the code of the highest-priority active enabled source. From highest to lowest: line status error 0x6, received data 0x4, character time-out 0xC, transmit holding empty 0x2, modem status change 0x0.
- R5: Bits 7:6 of the identification byte read 11 while the FIFO-enabled input is high, and 00 otherwise. Bits 5:4 always read 0.
- R6: Each source counts only while its enable bit is set. Enable bit 0 covers both received data and time-out, bit 1 holding empty, bit 2 line status, and bit 3 modem status.
- R7: The holding-empty condition is armed by a rising edge of the empty input. It is also armed by a write that sets enable bit 1 while the empty input is high.
- R8: A read strobe at offset 2 disarms the holding-empty condition when code 0x2 is the value being reported. The same read while another code is reported leaves the condition armed.
- R9: A write to offset 0 while divisor access is low disarms the holding-empty condition. A disarm in the same cycle as an arming event wins.
- R10: The interrupt request is high exactly when the gate input is high and bit 0 of the identification byte is 0.
- R11: Read data is combinational from the address. Offset 2 always returns the identification byte. Offset 1 returns the enable register only while divisor access is low. Every other case returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| div_access_i | input | 1 | Divisor-access bit from line control |
| line_err_i | input | 1 | Receiver line status error present |
| rx_avail_i | input | 1 | Received data available |
| rx_timeout_i | input | 1 | Character time-out |
| tx_empty_i | input | 1 | Holding register empty level |
| modem_chg_i | input | 1 | Modem status change present |
| fifo_en_i | input | 1 | FIFOs enabled |
| irq_gate_i | input | 1 | Interrupt output enable from modem control |
| ident_o | output | 8 | Identification byte |
| pending_n_o | output | 1 | Low while an interrupt is pending |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default three-bit address. That width makes every offset from 0 to 7 reachable, so the zero reads at unused offsets are exercised alongside the three decoded ones. The random phase drives all five sources, the divisor-access bit, the FIFO flag and the gate independently. Those combinations reach the rare cases: an ident read that lands while a higher source hides holding empty, and a holding write that coincides with a new empty edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned EN_W    = 4;
  localparam int unsigned NUM_SRC = 5;

  // enable bit positions
  localparam int unsigned EN_RXDATA = 0;
  localparam int unsigned EN_THRE   = 1;
  localparam int unsigned EN_LINE   = 2;
  localparam int unsigned EN_MODEM  = 3;

  // register offsets
  localparam int unsigned OFS_DATA   = 0;
  localparam int unsigned OFS_ENABLE = 1;
  localparam int unsigned OFS_IDENT  = 2;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // rank 0 is highest priority
  function automatic irq_id_e rank_code(int unsigned rank);
    case (rank)
      0:       return ID_LINE;
      1:       return ID_RXDATA;
      2:       return ID_TIMEOUT;
      3:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              div_access_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [EN_W-1:0]   en_o,
  output logic              thre_en_rise_o
);
  logic            sel;
  logic [EN_W-1:0] en_q;

  assign sel = wr_i && !div_access_i && (addr_i == ADDR_W'(OFS_ENABLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  en_q <= '0;
    else if (sel) en_q <= wdata_i[EN_W-1:0];
  end

  assign en_o           = en_q;
  assign thre_en_rise_o = sel && wdata_i[EN_THRE] && !en_q[EN_THRE];
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_empty_i,
  input  logic en_rise_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, set;

  assign set = tx_empty_i && (!prev_q || en_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= tx_empty_i;
      if (clr_i)    pend_q <= 1'b0;   // disarm wins
      else if (set) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,  // index = rank
  output irq_id_e            code_o,
  output logic               any_o
);
  always_comb begin
    code_o = ID_NONE;
    any_o  = 1'b0;
    // walk lowest to highest priority so the highest overrides
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (req_i[r]) begin
        code_o = rank_code(r);
        any_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              div_access_i,
  input  logic              line_err_i,
  input  logic              rx_avail_i,
  input  logic              rx_timeout_i,
  input  logic              tx_empty_i,
  input  logic              modem_chg_i,
  input  logic              fifo_en_i,
  input  logic              irq_gate_i,
  output logic [7:0]        ident_o,
  output logic              pending_n_o,
  output logic              irq_o
);
  logic [EN_W-1:0]    ier_q;
  logic               thre_en_rise, thre_pend, thre_clr, any;
  logic [NUM_SRC-1:0] req;
  irq_id_e            code;

  uart_irq_enable_reg #(.ADDR_W(ADDR_W)) u_en (
    .clk_i, .rst_ni, .wr_i, .addr_i, .div_access_i,
    .wdata_i,
    .en_o           (ier_q),
    .thre_en_rise_o (thre_en_rise)
  );

  assign thre_clr = (rd_i && addr_i == ADDR_W'(OFS_IDENT) && code == ID_THRE)
                 || (wr_i && !div_access_i && addr_i == ADDR_W'(OFS_DATA));

  uart_irq_thre_track u_thre (
    .clk_i, .rst_ni,
    .tx_empty_i,
    .en_rise_i (thre_en_rise),
    .clr_i     (thre_clr),
    .pend_o    (thre_pend)
  );

  assign req[0] = line_err_i   && ier_q[EN_LINE];
  assign req[1] = rx_avail_i   && ier_q[EN_RXDATA];
  assign req[2] = rx_timeout_i && ier_q[EN_RXDATA];
  assign req[3] = thre_pend    && ier_q[EN_THRE];
  assign req[4] = modem_chg_i  && ier_q[EN_MODEM];

  uart_irq_prio_enc u_enc (
    .req_i  (req),
    .code_o (code),
    .any_o  (any)
  );

  assign ident_o     = {{2{fifo_en_i}}, 2'b00, code};
  assign pending_n_o = !any;
  assign irq_o       = irq_gate_i && any;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_IDENT))
      rdata_o = ident_o;
    else if (addr_i == ADDR_W'(OFS_ENABLE) && !div_access_i)
      rdata_o = {{(8-EN_W){1'b0}}, ier_q};
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              div_access_i,
  input logic              fifo_en_i,
  input logic              irq_gate_i,
  input logic [7:0]        ident_o,
  input logic              pending_n_o,
  input logic              irq_o,
  input logic [3:0]        ier_q
);
  // R10
  irq_gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_gate_i |-> !irq_o);
  // R10
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !pending_n_o);
  // R5
  fifo_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_o[7:6] == {2{fifo_en_i}}) && (ident_o[5:4] == 2'b00));
  // R6
  no_enable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_q == 4'h0) |-> pending_n_o);
  // R8
  thre_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(2) && ident_o[3:0] == 4'h2) |=> (ident_o[3:0] != 4'h2));
  // R9
  thre_write_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !div_access_i && addr_i == ADDR_W'(0)) |=> (ident_o[3:0] != 4'h2));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .div_access_i, .fifo_en_i,
  .irq_gate_i, .ident_o, .pending_n_o, .irq_o, .ier_q(ier_q)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int ADDR_W = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0;
  logic dlab = 0, line = 0, rx = 0, to = 0, tx = 0, mdm = 0, fifo = 0, gate = 0;
  logic [7:0] rdata, ident;
  logic pend_n, irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [3:0] ier_m = '0;
  bit thre_m = 0, prev_m = 0;

  always #4 clk_i = ~clk_i;

  uart_irq_ident #(.ADDR_W(ADDR_W)) u_uart_irq_ident (
    .clk_i, .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .div_access_i(dlab), .line_err_i(line), .rx_avail_i(rx),
    .rx_timeout_i(to), .tx_empty_i(tx), .modem_chg_i(mdm), .fifo_en_i(fifo),
    .irq_gate_i(gate), .ident_o(ident), .pending_n_o(pend_n), .irq_o(irq)
  );

  function automatic logic [3:0] model_code();
    if (ier_m[2] && line)      return 4'h6;
    else if (ier_m[0] && rx)   return 4'h4;
    else if (ier_m[0] && to)   return 4'hC;
    else if (ier_m[1] && thre_m) return 4'h2;
    else if (ier_m[3] && mdm)  return 4'h0;
    else                       return 4'h1;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h @%0t", req, what, act, exp, $time);
    end
  endtask

  // compare all outputs, then advance the model across the next edge
  task automatic tick();
    logic [3:0] c;
    logic [7:0] id_e, rd_e;
    logic [3:0] old_ier;
    bit clr, set, ier_wr;
    #1;
    c    = model_code();
    id_e = {{2{fifo}}, 2'b00, c};
    if (addr == 3'd2)               rd_e = id_e;          // R11
    else if (addr == 3'd1 && !dlab) rd_e = {4'h0, ier_m}; // R2
    else                            rd_e = 8'h00;          // R11
    check("R4", "ident", ident, id_e);
    check("R3", "pending_n", {7'b0, pend_n}, {7'b0, c[0]});
    check("R10", "irq", {7'b0, irq}, {7'b0, gate && !c[0]});
    check("R11", "rdata", rdata, rd_e);
    old_ier = ier_m;
    ier_wr  = wr && addr == 3'd1 && !dlab;
    if (ier_wr) ier_m = wdata[3:0];
    clr = (rd && addr == 3'd2 && c == 4'h2) || (wr && addr == 3'd0 && !dlab);
    set = tx && (!prev_m || (ier_wr && ier_m[1] && !old_ier[1]));
    if (clr)      thre_m = 0;
    else if (set) thre_m = 1;
    prev_m = tx;
    @(negedge clk_i);
    wr = 0; rd = 0;
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; tick();
  endtask

  task automatic rd_reg(logic [2:0] a);
    addr = a; rd = 1; tick();
  endtask

  initial begin
    @(negedge clk_i);
    // R1: reset state
    #1;
    check("R1", "reset ident", ident, 8'h01);
    check("R1", "reset irq", {7'b0, irq}, 8'h00);
    addr = 3'd1;
    #1 check("R1", "reset enable", rdata, 8'h00);
    @(negedge clk_i);
    rst_ni = 1;
    tick();

    // R2: enable write, upper bits dropped; blocked while divisor access set
    wr_reg(3'd1, 8'hF5);
    addr = 3'd1; #1 check("R2", "enable readback", rdata, 8'h05);
    tick();
    dlab = 1; wr_reg(3'd1, 8'h0A);
    dlab = 0; addr = 3'd1; #1 check("R2", "dlab write ignored", rdata, 8'h05);
    tick();

    // R6/R4: received data vs time-out under enable bit 0
    rx = 1; to = 1; tick();
    #1 check("R4", "rx over timeout", ident, 8'h04);
    tick();
    rx = 0; tick();
    #1 check("R4", "timeout code", ident, 8'h0C);
    tick();
    wr_reg(3'd1, 8'h00);
    #1 check("R6", "disabled timeout", ident, 8'h01);
    tick();
    to = 0;

    // R7: enabling while already empty arms the holding-empty condition
    tx = 1; tick(); tick();
    wr_reg(3'd1, 8'h02);
    #1 check("R7", "armed by enable", ident, 8'h02);
    tick();
    // R8: read while reported disarms
    rd_reg(3'd2);
    #1 check("R8", "read clears", ident, 8'h01);
    tick();
    // R7: rising edge re-arms; R8: read hidden behind line status keeps it
    tx = 0; tick(); tx = 1; tick();
    wr_reg(3'd1, 8'h06);
    line = 1; rd_reg(3'd2);
    line = 0; #1 check("R8", "hidden read keeps", ident, 8'h02);
    tick();
    // R9: holding write disarms
    wr_reg(3'd0, 8'h41);
    #1 check("R9", "holding write clears", ident, 8'h01);
    tick();

    // R5 and R10
    fifo = 1; mdm = 1; wr_reg(3'd1, 8'h08);
    #1 check("R5", "fifo markers", ident, 8'hC0);
    check("R10", "gated irq", {7'b0, irq}, 8'h00);
    tick();
    gate = 1; tick();
    #1 check("R10", "irq raised", {7'b0, irq}, 8'h01);
    tick();

    // random phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      line = r[0] & r[1]; rx = r[2] & r[3]; to = r[4] & r[5];
      tx = r[6]; mdm = r[7]; fifo = r[8]; gate = r[9]; dlab = r[10] & r[11];
      addr = r[14:12]; wdata = r[23:16];
      wr = r[24] & r[25]; rd = !wr && r[26];
      tick();
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule